// File: doc/BRIEF.md
# Role-Banded Stair-Step PWM Cell

This block sits inside one full-bridge cell of a cascaded multilevel converter. Three such cells stacked in series build a seven-level output: each cell adds either a positive step, a negative step or nothing. The cell takes a signed reference sample and turns it into four bridge gate commands. Which voltage step it supplies depends on the role code for the present half-period. Role 1 owns the lowest band of reference magnitude, role 2 the middle band and role 3 the top band. Role 0 parks the cell in bypass.

Within its band, the cell modulates against a triangular carrier. The duty ratio grows linearly from 0 at the band's lower limit to 1 at its upper limit. Below the band the cell stays in bypass, and above it the cell is held fully on. Separate limits and roles are supplied for the positive and negative half-periods. An amplitude factor rescales the reference magnitude in one flagged half-period only. A cell with a single failed transistor can be flagged as half-bridge; it then drives only its one usable polarity and sits in bypass during the other half-period. A small state machine, with the states BLANK, ZERO, POS and NEG, sequences the gates. It inserts a fixed all-off gap before any switch turns on. Its transitions are: ZERO, POS or NEG go to BLANK whenever the requested drive differs from the present state, and BLANK goes to the requested state once its gap counter expires. Reset enters BLANK.

Top module: `stair_pwm_cell`

## Requirements
- R1: Reset holds all four gates low and enters the BLANK state; the cell leaves BLANK only after DEAD_CYC clock cycles with reset released.
- R2: Role code 0 in the active half-period forces the bypass pattern (lo_a and lo_b high, hi_a and hi_b low) for any reference value.
- R3: A reference magnitude at or below the lower limit of the active band gives the bypass pattern.
- R4: A reference magnitude at or above the upper limit of the active band, and above its lower limit, holds the cell fully on with no switching.
- R5: Inside the band, over one carrier period, the cell is on for the fraction (|ref| - lower)/(upper - lower) of the period, less the blanking gap.
- R6: A reference with its sign bit clear drives the positive pattern (hi_a and lo_b). A reference with its sign bit set drives the negative pattern (lo_a and hi_b). The sign bit also selects role_pos or role_neg and the matching limit pair.
- R7: The bands are role 1 = [0, lim1], role 2 = [lim1, lim2] and role 3 = [lim2, 2^(REF_W-1)-1], using the limit pair of the active half-period. The magnitude of the most negative reference saturates to 2^(REF_W-1)-1.
- R8: amp_scale is an unsigned fraction with unity at 2^(AMP_W-1). It multiplies the magnitude only when the reference sign bit equals amp_neg (0 = positive half, 1 = negative half). The product saturates at 2^(REF_W-1)-1.
- R9: With hb_fault high, the cell is forced to bypass in the half-period it cannot drive. hb_pol = 0 means positive only and hb_pol = 1 means negative only. The usable half operates normally.
- R10: Every gate turn-on is preceded by at least DEAD_CYC cycles with all gates low. The two switches of one leg are never on together.
- R11: The carrier counts 0 up to CAR_MAX and back down, one step per carrier_tick. It holds its value when no tick arrives, so the gates are then static for a static reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sample | input | REF_W | Two's-complement reference sample |
| role_pos | input | 2 | Role code for the positive half-period |
| role_neg | input | 2 | Role code for the negative half-period |
| lim1_pos | input | REF_W-1 | Role 1/2 boundary, positive half |
| lim2_pos | input | REF_W-1 | Role 2/3 boundary, positive half |
| lim1_neg | input | REF_W-1 | Role 1/2 boundary, negative half |
| lim2_neg | input | REF_W-1 | Role 2/3 boundary, negative half |
| amp_scale | input | AMP_W | Amplitude factor, unity = 2^(AMP_W-1) |
| amp_neg | input | 1 | Half-period the factor applies to (0 = positive, 1 = negative) |
| hb_fault | input | 1 | Cell restricted to half-bridge operation |
| hb_pol | input | 1 | Usable polarity in fault (0 = positive, 1 = negative) |
| carrier_tick | input | 1 | Carrier advance strobe |
| hi_a | output | 1 | Leg A upper switch gate |
| lo_a | output | 1 | Leg A lower switch gate |
| hi_b | output | 1 | Leg B upper switch gate |
| lo_b | output | 1 | Leg B lower switch gate |

## Verification
The band properties assume each limit pair is ordered, with lim1 no greater than lim2. They also assume that the factor and flag are set up before the half-period they act on. The bench only ever programs ordered pairs and changes settings between scenarios, then lets the cell settle before it measures. The gate properties assume nothing about the inputs: they hold for any sequence of requested drives, and the bench checks the all-off gap across every pattern change it observes.

// File: rtl/stair_pkg.sv
package stair_pkg;

    typedef enum logic [1:0] {
        DRV_ZERO = 2'd0,
        DRV_POS  = 2'd1,
        DRV_NEG  = 2'd2
    } drive_t;

    typedef enum logic [1:0] {
        ST_BLANK = 2'd0,
        ST_ZERO  = 2'd1,
        ST_POS   = 2'd2,
        ST_NEG   = 2'd3
    } gate_state_t;

endpackage

// File: rtl/tri_carrier.sv
module tri_carrier #(
    parameter int CAR_MAX = 2500,
    parameter int CAR_W   = $clog2(CAR_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CAR_W-1:0] car
);

    localparam logic [CAR_W-1:0] TOP      = CAR_W'(CAR_MAX);
    localparam logic [CAR_W-1:0] TOP_LESS = CAR_W'(CAR_MAX - 1);

    logic rising;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            car    <= '0;
            rising <= 1'b1;
        end else if (tick) begin
            if (rising) begin
                car <= car + 1'b1;
                if (car == TOP_LESS) rising <= 1'b0;
            end else begin
                car <= car - 1'b1;
                if (car == CAR_W'(1)) rising <= 1'b1;
            end
        end
    end

    // R11: the counter never leaves the triangle range
    p_carrier_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        car <= TOP);

    // R11: no tick, no movement
    p_carrier_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(car));

endmodule

// File: rtl/band_select.sv
module band_select
    import stair_pkg::*;
#(
    parameter int REF_W   = 16,
    parameter int AMP_W   = 16,
    parameter int CAR_MAX = 2500,
    parameter int CAR_W   = $clog2(CAR_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [REF_W-1:0]   ref_sample,
    input  logic [1:0]         role_pos,
    input  logic [1:0]         role_neg,
    input  logic [REF_W-2:0]   lim1_pos,
    input  logic [REF_W-2:0]   lim2_pos,
    input  logic [REF_W-2:0]   lim1_neg,
    input  logic [REF_W-2:0]   lim2_neg,
    input  logic [AMP_W-1:0]   amp_scale,
    input  logic               amp_neg,
    input  logic               hb_fault,
    input  logic               hb_pol,
    input  logic [CAR_W-1:0]   car,
    output drive_t             tgt_q
);

    localparam int MAG_W = REF_W - 1;
    localparam int PRD_W = MAG_W + AMP_W;
    localparam int CMP_W = MAG_W + CAR_W;
    localparam logic [MAG_W-1:0] MAG_MAX = '1;
    localparam logic [CMP_W-1:0] CMAX_EXT = CMP_W'(CAR_MAX);

    logic               neg;
    logic [REF_W-1:0]   nref;
    logic [MAG_W-1:0]   raw_mag;
    logic [PRD_W-1:0]   prod;
    logic [MAG_W:0]     scaled;
    logic [MAG_W-1:0]   sat_mag;
    logic [MAG_W-1:0]   mag;
    logic [1:0]         role_sel;
    logic [MAG_W-1:0]   l1, l2, lo, hi;
    logic               blocked;
    logic [CMP_W-1:0]   lhs, rhs;
    logic               on;
    drive_t             tgt_d;

    // magnitude with saturation of the most negative code
    always_comb begin
        neg  = ref_sample[REF_W-1];
        nref = ~ref_sample + 1'b1;
        if (!neg)
            raw_mag = ref_sample[MAG_W-1:0];
        else if (nref[REF_W-1])
            raw_mag = MAG_MAX;
        else
            raw_mag = nref[MAG_W-1:0];
    end

    // amplitude factor for the flagged half-period only
    always_comb begin
        prod    = PRD_W'(raw_mag) * PRD_W'(amp_scale);
        scaled  = prod[PRD_W-1:AMP_W-1];
        sat_mag = (scaled > {1'b0, MAG_MAX}) ? MAG_MAX : scaled[MAG_W-1:0];
        mag     = (neg == amp_neg) ? sat_mag : raw_mag;
    end

    // half-period role and band edges
    always_comb begin
        role_sel = neg ? role_neg : role_pos;
        l1       = neg ? lim1_neg : lim1_pos;
        l2       = neg ? lim2_neg : lim2_pos;
        unique case (role_sel)
            2'd1:    begin lo = '0; hi = l1;      end
            2'd2:    begin lo = l1; hi = l2;      end
            2'd3:    begin lo = l2; hi = MAG_MAX; end
            default: begin lo = '0; hi = '0;      end
        endcase
        blocked = hb_fault && (neg != hb_pol);
    end

    // duty compare: (mag-lo)/(hi-lo) > car/CAR_MAX, cross-multiplied
    always_comb begin
        lhs = CMP_W'(mag - lo) * CMAX_EXT;
        rhs = CMP_W'(car) * CMP_W'(hi - lo);
        if (role_sel == 2'd0 || blocked)
            on = 1'b0;
        else if (mag <= lo)
            on = 1'b0;
        else if (mag >= hi)
            on = 1'b1;
        else
            on = (lhs > rhs);
        tgt_d = on ? (neg ? DRV_NEG : DRV_POS) : DRV_ZERO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgt_q <= DRV_ZERO;
        else        tgt_q <= tgt_d;
    end

    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (role_sel == 2'd0) |=> (tgt_q == DRV_ZERO));

    p_below_band_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mag <= lo) |=> (tgt_q == DRV_ZERO));

    p_above_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (role_sel != 2'd0 && !blocked && mag > lo && mag >= hi) |=> (tgt_q != DRV_ZERO));

    p_sign_r6: assert property (@(posedge clk) disable iff (!rst_n)
        neg |=> (tgt_q != DRV_POS));

    p_fault_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_fault && neg != hb_pol) |=> (tgt_q == DRV_ZERO));

endmodule

// File: rtl/gate_sequencer.sv
module gate_sequencer
    import stair_pkg::*;
#(
    parameter int DEAD_CYC = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  drive_t tgt,
    output logic   hi_a,
    output logic   lo_a,
    output logic   hi_b,
    output logic   lo_b
);

    localparam int DCW = $clog2(DEAD_CYC + 1);
    localparam logic [DCW-1:0] DLOAD = DCW'(DEAD_CYC - 1);

    gate_state_t     state, state_nx, tgt_state;
    logic [DCW-1:0]  cnt, cnt_nx;
    logic [3:0]      gv;

    always_comb begin
        unique case (tgt)
            DRV_POS: tgt_state = ST_POS;
            DRV_NEG: tgt_state = ST_NEG;
            default: tgt_state = ST_ZERO;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_BLANK;
            cnt   <= DLOAD;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_BLANK: begin
                if (cnt == '0) state_nx = tgt_state;
                else           cnt_nx   = cnt - 1'b1;
            end
            ST_ZERO, ST_POS, ST_NEG: begin
                if (tgt_state != state) begin
                    state_nx = ST_BLANK;
                    cnt_nx   = DLOAD;
                end
            end
            default: begin
                state_nx = ST_BLANK;
                cnt_nx   = DLOAD;
            end
        endcase
    end

    // outputs
    always_comb begin
        {hi_a, lo_a, hi_b, lo_b} = 4'b0000;
        unique case (state)
            ST_ZERO: begin lo_a = 1'b1; lo_b = 1'b1; end
            ST_POS:  begin hi_a = 1'b1; lo_b = 1'b1; end
            ST_NEG:  begin lo_a = 1'b1; hi_b = 1'b1; end
            default: ;
        endcase
    end

    assign gv = {hi_a, lo_a, hi_b, lo_b};

    p_gap_hi_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_a) |-> $past(gv == 4'b0000));
    p_gap_lo_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_a) |-> $past(gv == 4'b0000));
    p_gap_hi_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_b) |-> $past(gv == 4'b0000));
    p_gap_lo_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_b) |-> $past(gv == 4'b0000));
    p_leg_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_a && lo_a));
    p_leg_b_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_b && lo_b));

    // R1: first cycle after reset is blanked
    p_reset_blank_r1: assert property (@(posedge clk)
        !rst_n |=> (gv == 4'b0000));

endmodule

// File: rtl/stair_pwm_cell.sv
module stair_pwm_cell
    import stair_pkg::*;
#(
    parameter int REF_W    = 16,
    parameter int AMP_W    = 16,
    parameter int CAR_MAX  = 2500,
    parameter int DEAD_CYC = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REF_W-1:0] ref_sample,
    input  logic [1:0]       role_pos,
    input  logic [1:0]       role_neg,
    input  logic [REF_W-2:0] lim1_pos,
    input  logic [REF_W-2:0] lim2_pos,
    input  logic [REF_W-2:0] lim1_neg,
    input  logic [REF_W-2:0] lim2_neg,
    input  logic [AMP_W-1:0] amp_scale,
    input  logic             amp_neg,
    input  logic             hb_fault,
    input  logic             hb_pol,
    input  logic             carrier_tick,
    output logic             hi_a,
    output logic             lo_a,
    output logic             hi_b,
    output logic             lo_b
);

    localparam int CAR_W = $clog2(CAR_MAX + 1);

    logic [CAR_W-1:0] car;
    drive_t           tgt;

    tri_carrier #(
        .CAR_MAX (CAR_MAX),
        .CAR_W   (CAR_W)
    ) u_carrier (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (carrier_tick),
        .car   (car)
    );

    band_select #(
        .REF_W   (REF_W),
        .AMP_W   (AMP_W),
        .CAR_MAX (CAR_MAX),
        .CAR_W   (CAR_W)
    ) u_band (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_sample (ref_sample),
        .role_pos   (role_pos),
        .role_neg   (role_neg),
        .lim1_pos   (lim1_pos),
        .lim2_pos   (lim2_pos),
        .lim1_neg   (lim1_neg),
        .lim2_neg   (lim2_neg),
        .amp_scale  (amp_scale),
        .amp_neg    (amp_neg),
        .hb_fault   (hb_fault),
        .hb_pol     (hb_pol),
        .car        (car),
        .tgt_q      (tgt)
    );

    gate_sequencer #(
        .DEAD_CYC (DEAD_CYC)
    ) u_gates (
        .clk   (clk),
        .rst_n (rst_n),
        .tgt   (tgt),
        .hi_a  (hi_a),
        .lo_a  (lo_a),
        .hi_b  (hi_b),
        .lo_b  (lo_b)
    );

endmodule

// File: tb/test_stair_pwm_cell.sv
`timescale 1ns/1ps
module test_stair_pwm_cell;

    localparam int REF_W = 16;
    localparam int AMP_W = 16;
    localparam int CMAX  = 2500;
    localparam int DEAD  = 8;
    localparam int PER   = 2 * CMAX;
    localparam int UNITY = 32768;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [REF_W-1:0] ref_sample = '0;
    logic [1:0] role_pos = 2'd0, role_neg = 2'd0;
    logic [REF_W-2:0] lim1_pos = 15'd10000, lim2_pos = 15'd20000;
    logic [REF_W-2:0] lim1_neg = 15'd12000, lim2_neg = 15'd22000;
    logic [AMP_W-1:0] amp_scale = 16'(UNITY);
    logic amp_neg = 1'b0, hb_fault = 1'b0, hb_pol = 1'b0, carrier_tick = 1'b1;
    logic hi_a, lo_a, hi_b, lo_b;

    int n_checks = 0, n_fail = 0;
    int c_pos, c_neg, c_zero, c_off, c_gapbad, c_changes;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stair_pwm_cell #(.REF_W(REF_W), .AMP_W(AMP_W), .CAR_MAX(CMAX), .DEAD_CYC(DEAD)) i_stair_pwm_cell (
        .clk(clk), .rst_n(rst_n), .ref_sample(ref_sample),
        .role_pos(role_pos), .role_neg(role_neg),
        .lim1_pos(lim1_pos), .lim2_pos(lim2_pos), .lim1_neg(lim1_neg), .lim2_neg(lim2_neg),
        .amp_scale(amp_scale), .amp_neg(amp_neg), .hb_fault(hb_fault), .hb_pol(hb_pol),
        .carrier_tick(carrier_tick), .hi_a(hi_a), .lo_a(lo_a), .hi_b(hi_b), .lo_b(lo_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic near(input string tag, input int act, input int exp, input int tol);
        check((act >= exp - tol) && (act <= exp + tol), tag, act, exp);
    endtask

    task automatic settle();
        repeat (60) @(negedge clk);
    endtask

    // count gate patterns over n cycles, sampled at the falling edge
    task automatic measure(input int n);
        logic [3:0] prev, cur;
        int off_run;
        c_pos = 0; c_neg = 0; c_zero = 0; c_off = 0; c_gapbad = 0; c_changes = 0;
        @(negedge clk);
        prev = {hi_a, lo_a, hi_b, lo_b};
        off_run = DEAD;
        for (int i = 0; i < n; i++) begin
            cur = {hi_a, lo_a, hi_b, lo_b};
            case (cur)
                4'b1001: c_pos++;
                4'b0110: c_neg++;
                4'b0101: c_zero++;
                4'b0000: c_off++;
                default: c_gapbad++;
            endcase
            if (cur != prev) c_changes++;
            if (cur == 4'b0000) off_run++;
            else begin
                if (cur != prev && (prev != 4'b0000 || off_run < DEAD)) c_gapbad++;
                off_run = 0;
            end
            prev = cur;
            @(negedge clk);
        end
    endtask

    function automatic int duty_cycles(input int mag, input int lo, input int hi);
        return ((mag - lo) * PER) / (hi - lo);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check({hi_a, lo_a, hi_b, lo_b} == 4'b0000, "R1 gates low in reset", int'({hi_a, lo_a, hi_b, lo_b}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({hi_a, lo_a, hi_b, lo_b} == 4'b0000, "R1 still blank after release", int'({hi_a, lo_a, hi_b, lo_b}), 0);
        repeat (20) @(negedge clk);
        check({hi_a, lo_a, hi_b, lo_b} == 4'b0101, "R1 bypass after gap", int'({hi_a, lo_a, hi_b, lo_b}), 5);
    endtask

    task automatic t_role_zero();
        role_pos = 2'd0; ref_sample = 16'(30000); settle(); measure(PER);
        check(c_zero == PER, "R2 role 0 bypass", c_zero, PER);
    endtask

    task automatic t_band_mid();
        role_pos = 2'd1; ref_sample = 16'(5000); settle(); measure(PER);
        near("R5 R6 role1 half duty", c_pos, duty_cycles(5000, 0, 10000), 30);
        check(c_neg == 0, "R6 no negative drive", c_neg, 0);
        check(c_gapbad == 0, "R10 gap before turn-on", c_gapbad, 0);
    endtask

    task automatic t_bands();
        role_pos = 2'd2; ref_sample = 16'(5000); settle(); measure(PER);
        check(c_zero == PER, "R3 below role2 band", c_zero, PER);
        ref_sample = 16'(25000); settle(); measure(PER);
        check(c_pos == PER, "R4 above role2 band held on", c_pos, PER);
        ref_sample = 16'(12500); settle(); measure(PER);
        near("R7 role2 quarter duty", c_pos, duty_cycles(12500, 10000, 20000), 30);
        role_neg = 2'd3; ref_sample = 16'(-27000); settle(); measure(PER);
        near("R7 R6 role3 negative band", c_neg, duty_cycles(27000, 22000, 32767), 30);
        check(c_pos == 0, "R6 no positive in negative half", c_pos, 0);
        check(c_gapbad == 0, "R10 gap negative band", c_gapbad, 0);
        ref_sample = 16'h8000; settle(); measure(PER);
        check(c_neg == PER, "R7 most negative saturates", c_neg, PER);
    endtask

    task automatic t_amp();
        role_pos = 2'd1; ref_sample = 16'(5000);
        amp_scale = 16'(UNITY / 2); amp_neg = 1'b0; settle(); measure(PER);
        near("R8 factor on positive half", c_pos, duty_cycles(2500, 0, 10000), 30);
        amp_neg = 1'b1; settle(); measure(PER);
        near("R8 factor ignored on other half", c_pos, duty_cycles(5000, 0, 10000), 30);
        role_pos = 2'd3; ref_sample = 16'(30000); amp_scale = 16'hFFFF; amp_neg = 1'b0;
        settle(); measure(PER);
        check(c_pos == PER, "R8 saturated product full on", c_pos, PER);
        amp_scale = 16'(UNITY);
    endtask

    task automatic t_fault();
        hb_fault = 1'b1; hb_pol = 1'b0;
        role_neg = 2'd1; ref_sample = 16'(-5000); settle(); measure(PER);
        check(c_zero == PER, "R9 blocked half bypass", c_zero, PER);
        role_pos = 2'd1; ref_sample = 16'(5000); settle(); measure(PER);
        near("R9 usable half still modulates", c_pos, duty_cycles(5000, 0, 10000), 30);
        hb_pol = 1'b1; settle(); measure(PER);
        check(c_zero == PER, "R9 positive blocked when negative only", c_zero, PER);
        hb_fault = 1'b0;
    endtask

    task automatic t_freeze();
        role_pos = 2'd1; ref_sample = 16'(5000); settle();
        carrier_tick = 1'b0; settle(); measure(2000);
        check(c_changes == 0, "R11 no tick static gates", c_changes, 0);
        carrier_tick = 1'b1; settle(); measure(PER);
        check(c_changes > 0, "R11 switching resumes with ticks", c_changes, 1);
    endtask

    initial begin
        t_reset();
        t_role_zero();
        t_band_mid();
        t_bands();
        t_amp();
        t_fault();
        t_freeze();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule